// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block sits between a group of peripheral interrupt sources and a small 8-bit CPU sequencer. Sources come in two kinds, chosen per bit by a parameter mask. Edge-kind sources turn a one-cycle event pulse into a sticky pending flag. Level-kind sources have no flag: they ask for service only while their condition is high. Each source has its own enable bit. A single global enable gates all of them. Among the enabled pending sources, the one with the lowest index wins.

The CPU reports its status through single-cycle strobes: a set-global-enable instruction, a clear-global-enable instruction, a return-from-interrupt, an instruction boundary and a sleep indication. A request is committed only at an instruction boundary. A response delay models the CPU saving its return address; this delay is longer when the core was asleep. After the delay the block raises `irq_o` and holds the vector address until the CPU acknowledges. The acknowledge clears the served flag and the global enable.

Vector slot zero of the table is kept for reset. Source `i` therefore sits at `base + (i+1)*VEC_STRIDE`. The base is either zero or a boot-region address, chosen by a relocation input.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_o` and `vec_o` are 0, and every enable, every flag and the global enable are clear.
- R2: An event pulse on an edge-kind source sets its flag even while its own enable or the global enable is clear. The flag stays pending until the source is served or software clears it.
- R3: Writing `clr_wdata_i` with `clr_we_i` high clears each flag whose bit is one. Bits written as zero leave their flags unchanged.
- R4: The acknowledge (`ack_i` while `irq_o` is high) drops `irq_o` in the next cycle and clears the served source's flag and the global enable. No further request is taken until the global enable is set again.
- R5: A level-kind source (bit 0 in `EDGE_MASK`) has no flag. A condition that goes away before the source is enabled is never served. Event pulses on that bit have no effect.
- R6: The lowest pending enabled index wins. `vec_o` equals `base + (index+1)*VEC_STRIDE` while `irq_o` is high, so slot 0 (reset) is never issued. `vec_o` is 0 otherwise.
- R7: After a set-global-enable or return-from-interrupt strobe, the next instruction boundary is blocked. A pending request is taken at the boundary after that.
- R8: A clear-global-enable strobe in the same cycle as a boundary stops a request from being taken at that boundary.
- R9: A request is taken only at a boundary. `irq_o` rises exactly `RESP_LAT` cycles after the take cycle, or `RESP_LAT+WAKE_LAT` cycles when `sleep_i` is high at the take.
- R10: With `relocate_i` high, the base is `BOOT_BASE` instead of 0.
- R11: A return-from-interrupt strobe sets the global enable. Setting the enable inside a handler (after the acknowledge) lets another request be taken there.
- R12: Several flags that became pending while the global enable was clear are served one at a time, in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Event pulses for edge-kind sources |
| lvl_i | input | NUM_SRC | Level requests for level-kind sources |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_SRC | New enable register value |
| clr_we_i | input | 1 | Write strobe for the flag clear |
| clr_wdata_i | input | NUM_SRC | Write-one-to-clear flag mask |
| gie_set_i | input | 1 | Set-global-enable instruction executed |
| gie_clr_i | input | 1 | Clear-global-enable instruction executed |
| reti_i | input | 1 | Return-from-interrupt executed |
| boundary_i | input | 1 | Instruction boundary, where a request may be taken |
| sleep_i | input | 1 | Core is asleep |
| relocate_i | input | 1 | Select the boot-region table base |
| ack_i | input | 1 | CPU acknowledge of the request |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | ADDR_W | Vector address while `irq_o` is high, else 0 |

## Verification
The hardest case to reach from the ports is the one-instruction hold-off: the boundary right after a set-enable or return strobe must be refused, while the boundary after it must be accepted. The stimulus produces it by first making sources pending with the global enable off. It then issues the strobe and offers two separate boundaries, watching for the blocked one and for the exact cycle in which the request rises. A second hard case is a boundary that falls in the same cycle as a clear strobe. The stimulus drives both in one cycle, then shows afterwards, by setting the enable again, that the flag was still pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_REQ  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_wdata_i,
    input  logic [NUM_SRC-1:0] ack_clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] flg;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] raw_req;

    always_comb begin
        bank_d   = bank_q;
        clr_mask = (clr_we_i ? clr_wdata_i : '0) | ack_clr_i;
        set_mask = evt_i & EDGE_MASK;
        if (en_we_i) begin
            bank_d.en = en_wdata_i;
        end
        // a new event in the same cycle as a clear keeps the flag set
        bank_d.flg = ((bank_q.flg & ~clr_mask) | set_mask) & EDGE_MASK;
        raw_req    = (bank_q.flg & EDGE_MASK) | (lvl_i & ~EDGE_MASK);
        pend_o     = raw_req & bank_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & EDGE_MASK)) |=>
            ((bank_q.flg & $past(evt_i & EDGE_MASK)) == $past(evt_i & EDGE_MASK)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((bank_q.flg & $past(clr_wdata_i & ~evt_i)) == '0));

    // R5
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & ~EDGE_MASK)) |=> ((pend_o & ~EDGE_MASK) == (lvl_i & ~EDGE_MASK & bank_q.en)));

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_resp_seq.sv
module irqc_resp_seq
    import irqc_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int RESP_LAT = 4,
    parameter int WAKE_LAT = 4,
    parameter int CNT_W    = $clog2(RESP_LAT + WAKE_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             sleep_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             ack_i,
    output logic             idle_o,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [CNT_W-1:0] LOAD_AWAKE  = CNT_W'(RESP_LAT - 1);
    localparam logic [CNT_W-1:0] LOAD_ASLEEP = CNT_W'(RESP_LAT + WAKE_LAT - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (take_i) begin
                    seq_d.st  = SEQ_WAIT;
                    seq_d.cnt = sleep_i ? LOAD_ASLEEP : LOAD_AWAKE;
                    seq_d.idx = idx_i;
                end
            end
            SEQ_WAIT: begin
                seq_d.cnt = seq_q.cnt - 1'b1;
                if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.st = SEQ_REQ;
                end
            end
            SEQ_REQ: begin
                if (ack_i) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle_o = (seq_q.st == SEQ_IDLE);
    assign req_o  = (seq_q.st == SEQ_REQ);
    assign idx_o  = seq_q.idx;

    // R9
    no_instant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && idle_o) |=> !req_o);

    // R4
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(idx_o)));

    // R4
    ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK  = 8'h3F,
    parameter int                 ADDR_W     = 16,
    parameter int                 VEC_STRIDE = 2,
    parameter logic [ADDR_W-1:0]  BOOT_BASE  = 16'h1C00,
    parameter int                 RESP_LAT   = 4,
    parameter int                 WAKE_LAT   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] clr_wdata_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    input  logic               boundary_i,
    input  logic               sleep_i,
    input  logic               relocate_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic gie;
        logic holdoff;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_clr;
    logic               hit;
    logic [IDX_W-1:0]   pick_idx;
    logic [IDX_W-1:0]   req_idx;
    logic               seq_idle;
    logic               seq_req;
    logic               take;
    logic               ack_done;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  slot;

    irqc_flag_bank #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_MASK(EDGE_MASK)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .lvl_i      (lvl_i),
        .en_we_i    (en_we_i),
        .en_wdata_i (en_wdata_i),
        .clr_we_i   (clr_we_i),
        .clr_wdata_i(clr_wdata_i),
        .ack_clr_i  (ack_clr),
        .pend_o     (pend)
    );

    irqc_prio_pick #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) u_pick (
        .pend_i(pend),
        .hit_o (hit),
        .idx_o (pick_idx)
    );

    irqc_resp_seq #(
        .IDX_W   (IDX_W),
        .RESP_LAT(RESP_LAT),
        .WAKE_LAT(WAKE_LAT)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .sleep_i(sleep_i),
        .idx_i  (pick_idx),
        .ack_i  (ack_i),
        .idle_o (seq_idle),
        .req_o  (seq_req),
        .idx_o  (req_idx)
    );

    assign ack_done = seq_req && ack_i;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_ackclr
            assign ack_clr[g] = ack_done && (req_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        // clearing the global enable is effective in the same cycle
        take = boundary_i && seq_idle && hit && ctl_q.gie
               && !gie_clr_i && !ctl_q.holdoff;
        if (gie_set_i || reti_i) begin
            ctl_d.holdoff = 1'b1;
        end else if (boundary_i) begin
            ctl_d.holdoff = 1'b0;
        end
        if (gie_clr_i || ack_done) begin
            ctl_d.gie = 1'b0;
        end else if (gie_set_i || reti_i) begin
            ctl_d.gie = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        base  = relocate_i ? BOOT_BASE : '0;
        slot  = ADDR_W'(req_idx) + ADDR_W'(1);
        irq_o = seq_req;
        vec_o = seq_req ? (base + slot * ADDR_W'(VEC_STRIDE)) : '0;
    end

    // R6
    never_reset_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o != base));

    // R8
    clr_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr_i && seq_idle) |=> seq_idle);

    // R7
    one_more_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gie_set_i || reti_i) && seq_idle) |=> ##1 seq_idle);

    // R4
    ack_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !ctl_q.gie);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt_i = '0;
    logic [NS-1:0] lvl_i = '0;
    logic          en_we_i = 1'b0;
    logic [NS-1:0] en_wdata_i = '0;
    logic          clr_we_i = 1'b0;
    logic [NS-1:0] clr_wdata_i = '0;
    logic          gie_set_i = 1'b0;
    logic          gie_clr_i = 1'b0;
    logic          reti_i = 1'b0;
    logic          boundary_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic          relocate_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          irq_o;
    logic [15:0]   vec_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .reti_i(reti_i),
        .boundary_i(boundary_i), .sleep_i(sleep_i), .relocate_i(relocate_i),
        .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_en(input logic [NS-1:0] v);
        en_we_i = 1'b1; en_wdata_i = v; tick(); en_we_i = 1'b0;
    endtask

    task automatic wr_clr(input logic [NS-1:0] v);
        clr_we_i = 1'b1; clr_wdata_i = v; tick(); clr_we_i = 1'b0; clr_wdata_i = '0;
    endtask

    task automatic fire(input logic [NS-1:0] v);
        evt_i = v; tick(); evt_i = '0;
    endtask

    task automatic sei();
        gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
    endtask

    task automatic reti();
        reti_i = 1'b1; tick(); reti_i = 1'b0;
    endtask

    // a boundary that must not lead to a request
    task automatic quiet_boundary(input string tag);
        bit seen = 0;
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (irq_o) seen = 1;
            tick();
        end
        check(!seen, tag, seen, 0);
    endtask

    // a boundary that must be taken; scoreboard gets the expected vector
    task automatic served_boundary(input logic [15:0] exp_vec, input int lat, input string tag);
        int n = 0;
        exp_q.push_back(exp_vec);
        tag_q.push_back(tag);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        while (!irq_o && n < 30) begin
            tick();
            n++;
        end
        check(n == lat - 1, {tag, " latency"}, n + 1, lat);
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        check(!irq_o && vec_o == 16'h0, {tag, " ack drops request (R4)"}, irq_o, 0);
    endtask

    // monitor: compares each request against the scoreboard
    logic irq_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && irq_o && !irq_prev) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected request actual=%0h expected=none", vec_o);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(vec_o == e, {t, " vector"}, vec_o, e);
            end
        end
        irq_prev = irq_o;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check(irq_o == 1'b0 && vec_o == 16'h0, "R1 reset outputs", {irq_o, vec_o}, 0);
        rst_n = 1'b1;
        tick();

        // R2 event latched while everything is disabled, R7 hold-off
        fire(8'h08);
        wr_en(8'h08);
        sei();
        quiet_boundary("R7 boundary after set-enable blocked");
        served_boundary(16'h0008, 4, "R2 latched flag served");

        // R4 global enable cleared by the acknowledge
        fire(8'h08);
        quiet_boundary("R4 no request while global enable clear");

        // R3 write of zero keeps the flag
        wr_clr(8'h00);
        sei();
        quiet_boundary("R7 hold-off again");
        served_boundary(16'h0008, 4, "R3 zero write kept flag");

        // R3 write of one clears it
        fire(8'h08);
        wr_clr(8'h08);
        sei();
        quiet_boundary("R7 hold-off");
        quiet_boundary("R3 cleared flag not served");

        // R12 priority order, R11 return re-enables
        gie_clr_i = 1'b1; tick(); gie_clr_i = 1'b0;
        wr_en(8'h3F);
        fire(8'h32);
        sei();
        quiet_boundary("R7 hold-off before burst");
        served_boundary(16'h0004, 4, "R12 first is source 1 (R6)");
        reti();
        quiet_boundary("R7 boundary after return blocked");
        served_boundary(16'h000A, 4, "R11 return re-enables, R12 source 4");
        reti();
        quiet_boundary("R7 hold-off after return");
        served_boundary(16'h000C, 4, "R12 source 5 last");

        // R5 level source lost when removed before enable
        lvl_i[6] = 1'b1;
        repeat (3) tick();
        lvl_i[6] = 1'b0;
        wr_en(8'h7F);
        sei();
        quiet_boundary("R7 hold-off");
        quiet_boundary("R5 removed level not served");
        lvl_i[6] = 1'b1;
        tick();
        served_boundary(16'h000E, 4, "R5 present level served");
        lvl_i[6] = 1'b0;
        fire(8'h40);
        sei();
        quiet_boundary("R7 hold-off");
        quiet_boundary("R5 event on level source ignored");

        // R8 clear in the same cycle as a boundary
        fire(8'h04);
        gie_clr_i = 1'b1;
        quiet_boundary("R8 clear with boundary blocks take");
        gie_clr_i = 1'b0;
        sei();
        quiet_boundary("R7 hold-off");
        served_boundary(16'h0006, 4, "R8 flag still pending afterwards");

        // R9 only at a boundary, longer when asleep
        fire(8'h01);
        sei();
        quiet_boundary("R7 hold-off");
        begin
            bit seen = 0;
            for (int k = 0; k < 12; k++) begin
                if (irq_o) seen = 1;
                tick();
            end
            check(!seen, "R9 no request without boundary", seen, 0);
        end
        sleep_i = 1'b1;
        served_boundary(16'h0002, 8, "R9 wake latency");
        sleep_i = 1'b0;

        // R10 relocated base, R11 nesting inside a handler
        relocate_i = 1'b1;
        fire(8'h01);
        sei();
        quiet_boundary("R7 hold-off");
        served_boundary(16'h1C02, 4, "R10 boot base");
        relocate_i = 1'b0;
        fire(8'h02);
        sei();
        quiet_boundary("R7 hold-off in handler");
        served_boundary(16'h0004, 4, "R11 nested request in handler");

        repeat (3) tick();
        check(exp_q.size() == 0, "R6 all expected requests seen", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule